// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a linear address into a physical address by walking a two-level page structure held in external memory. A request carries the linear address, the access kind (read or write) and the privilege (user or supervisor). The walker reads the directory entry at the directory base held in `root_base`. Depending on that entry, it either finishes there, with a large page that maps 4 MiB directly, or it reads one second-level table entry and finishes with a 4 KiB page. It checks presence, user rights and write rights across every level it touched. On success it sets the accessed flag, and on writes also the dirty flag, writing the entries back to memory through the same port.

The memory port is a single-outstanding request/response link. The walker pulses `mem_req_valid` for one cycle and then waits for one `mem_resp_valid` pulse, which answers both reads and writes. The walk ends with a one-cycle `done_valid`. At that point `done_fault` and `done_cause` report the outcome, and `done_paddr` carries the translated address on success. These three outputs hold their value until the next request is accepted.

Top module: `pt_walker`

## Requirements
- R1: A linear address is split as directory index [31:22], table index [21:12] and offset [11:0]. The directory entry is read at {root_base[31:12], index, 2'b00}, the table entry at {dir_entry[31:12], table index, 2'b00}, and a 4 KiB translation yields {table_entry[31:12], offset}.
- R2: When `large_en` is high and directory bit 7 (size) is set, no table is read and the result is {dir_entry[31:22], linear[21:0]}; entry bits 21:12 do not affect it. With `large_en` low, bit 7 is ignored and the entry points to a table.
- R3: An entry with bit 0 (present) clear ends the walk with a fault, cause bit 0 set, no further read and no memory write.
- R4: A user access faults with cause bit 2 unless bit 2 (user) is set in every entry of the walk (both levels, or the single large-page entry).
- R5: Bit 1 (writable) must be set at every level for a write to be allowed. A user write to a read-only page always faults with cause bit 1. A supervisor write to a read-only page faults only when `wp_en` is high.
- R6: On success the final entry gets bit 5 (accessed) and, for writes, bit 6 (dirty). On the 4 KiB path the directory entry also gets bit 5. An entry is written back only if its value changed, the final entry first, and a faulting walk writes nothing.
- R7: Entry bits 11:9 are ignored by the walker and are preserved in written-back entries.
- R8: `done_fault`, `done_cause` and `done_paddr` hold from the end of a walk until the next request is accepted; acceptance clears the fault and cause.
- R9: After reset the walker is idle with `req_ready` high and no memory request. `req_ready` is high only while idle. At most one memory request is outstanding, and `done_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 32 | Physical address of the directory, 4 KiB aligned |
| large_en | input | 1 | Enables directly mapped 4 MiB pages |
| wp_en | input | 1 | Makes read-only pages fault on supervisor writes too |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_resp_valid | input | 1 | One-cycle response to the pending request |
| mem_resp_rdata | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle end-of-walk pulse |
| done_fault | output | 1 | Walk ended in a page fault |
| done_cause | output | 3 | Fault cause: [0] not present, [1] write denied, [2] user denied |
| done_paddr | output | 32 | Physical address when no fault |

## Verification
The bench targets permission combinations split across levels: a user bit present only in the table entry, and a writable table entry under a read-only directory entry. A walker that checked only the final entry would return a translation for both. It runs supervisor writes to read-only pages with the write-protect control both low and high, since inverting that control either blocks kernel writes or lets them through. It counts reads and writes per walk. This exposes a large page that still reads a table, a size bit honoured while large pages are off, and a write-back of an entry whose flags were already set or of any entry after a fault. A final memory dump catches lost software bits, a dirty bit set on reads, and a directory accessed flag that was never written.

// File: rtl/pt_walker_pkg.sv
// Package: shared entry bit positions, walk states and fault cause type
// for the two-level page table walker.
package pt_walker_pkg;

    // Bit positions inside a page entry; the walker decodes these.
    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_USER     = 2;
    localparam int BIT_ACCESSED = 5;
    localparam int BIT_DIRTY    = 6;
    localparam int BIT_LARGE    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_WB_REQ,
        ST_WB_WAIT,
        ST_DONE
    } walk_state_t;

    // Fault cause: bit 2 user denied, bit 1 write denied, bit 0 not present.
    typedef struct packed {
        logic user_denied;
        logic write_denied;
        logic absent;
    } fault_cause_t;

endpackage

// File: rtl/pt_addr_gen.sv
// Module: pt_addr_gen
// Forms the entry addresses and the physical results of a walk.
// Assumes the offset width equals the index width plus the log2 of the
// entry size, so that one frame holds exactly one table.
module pt_addr_gen #(
    parameter int IDX_W    = 10,
    parameter int WB_LOG2  = 2,
    localparam int OFF_W   = IDX_W + WB_LOG2,
    localparam int ADDR_W  = 2 * IDX_W + OFF_W
) (
    input  logic [ADDR_W-1:0] root,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] dir_ent,
    input  logic [ADDR_W-1:0] leaf_ent,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [ADDR_W-1:0] pa_small,
    output logic [ADDR_W-1:0] pa_large
);
    // Pure concatenation of frame numbers, indices and offsets.
    always_comb begin
        dir_addr = {root[ADDR_W-1:OFF_W], vaddr[ADDR_W-1 -: IDX_W], {WB_LOG2{1'b0}}};
        tbl_addr = {dir_ent[ADDR_W-1:OFF_W], vaddr[OFF_W+IDX_W-1:OFF_W], {WB_LOG2{1'b0}}};
        pa_small = {leaf_ent[ADDR_W-1:OFF_W], vaddr[OFF_W-1:0]};
        pa_large = {leaf_ent[ADDR_W-1:OFF_W+IDX_W], vaddr[OFF_W+IDX_W-1:0]};
    end
endmodule

// File: rtl/pt_perm_check.sv
// Module: pt_perm_check
// Combines the rights of the upper and final entries of a walk. For a large
// page the same entry is fed to both sides. Assumes presence was checked.
module pt_perm_check (
    input  logic upper_user,
    input  logic upper_wr,
    input  logic leaf_user,
    input  logic leaf_wr,
    input  logic is_user,
    input  logic is_write,
    input  logic wp_on,
    output logic user_denied,
    output logic write_denied
);
    logic both_user;
    logic both_wr;

    // Rights are the AND over levels; supervisor writes bypass read-only unless wp_on.
    always_comb begin
        both_user    = upper_user & leaf_user;
        both_wr      = upper_wr & leaf_wr;
        user_denied  = is_user & ~both_user;
        write_denied = is_write & ~both_wr & (is_user | wp_on);
    end
endmodule

// File: rtl/pt_entry_update.sv
// Module: pt_entry_update
// Produces the entry with the accessed flag (and optionally dirty) set,
// and reports whether the value differs from the one read.
module pt_entry_update
    import pt_walker_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] ent_in,
    input  logic             set_dirty,
    output logic [ENT_W-1:0] ent_out,
    output logic             changed
);
    // OR in the flags; other bits, including software bits, pass through.
    always_comb begin
        ent_out               = ent_in;
        ent_out[BIT_ACCESSED] = 1'b1;
        if (set_dirty) begin
            ent_out[BIT_DIRTY] = 1'b1;
        end
        changed = (ent_out != ent_in);
    end
endmodule

// File: rtl/pt_walker.sv
// Module: pt_walker (top)
// Walks a two-level page structure for one request at a time: directory
// read, optional table read, write-back of changed entries, then a one-cycle
// done pulse. Assumes memory answers every request, reads and writes alike,
// with exactly one mem_resp_valid pulse at least one cycle later.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int WB_LOG2  = 2,
    localparam int OFF_W   = IDX_W + WB_LOG2,
    localparam int ADDR_W  = 2 * IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              large_en,
    input  logic              wp_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ADDR_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [ADDR_W-1:0] mem_resp_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic [2:0]        done_cause,
    output logic [ADDR_W-1:0] done_paddr
);
    walk_state_t       state;
    logic [ADDR_W-1:0] root_q, va_q, dir_ent_q;
    logic [ADDR_W-1:0] leaf_addr_q, leaf_new_q, dir_new_q;
    logic              wr_q, usr_q, large_q, wp_q;
    logic              wb_leaf_q, wb_dir_q;
    fault_cause_t      cause_q;
    logic              fault_q;
    logic [ADDR_W-1:0] paddr_q;

    logic [ADDR_W-1:0] dir_addr, tbl_addr, pa_small, pa_large;
    logic [ADDR_W-1:0] leaf_upd, dir_upd;
    logic              leaf_chg, dir_chg;
    logic              user_denied, write_denied;
    logic              in_dir_wait, is_large, resp_present;
    logic [ADDR_W-1:0] upper_ent;

    // Select which entry plays the upper level for the permission check.
    always_comb begin
        in_dir_wait  = (state == ST_DIR_WAIT);
        upper_ent    = in_dir_wait ? mem_resp_rdata : dir_ent_q;
        is_large     = large_q & mem_resp_rdata[BIT_LARGE];
        resp_present = mem_resp_rdata[BIT_PRESENT];
    end

    pt_addr_gen #(.IDX_W(IDX_W), .WB_LOG2(WB_LOG2)) u_addr (
        .root     (root_q),
        .vaddr    (va_q),
        .dir_ent  (dir_ent_q),
        .leaf_ent (mem_resp_rdata),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr),
        .pa_small (pa_small),
        .pa_large (pa_large)
    );

    pt_perm_check u_perm (
        .upper_user   (upper_ent[BIT_USER]),
        .upper_wr     (upper_ent[BIT_WRITABLE]),
        .leaf_user    (mem_resp_rdata[BIT_USER]),
        .leaf_wr      (mem_resp_rdata[BIT_WRITABLE]),
        .is_user      (usr_q),
        .is_write     (wr_q),
        .wp_on        (wp_q),
        .user_denied  (user_denied),
        .write_denied (write_denied)
    );

    pt_entry_update #(.ENT_W(ADDR_W)) u_leaf_upd (
        .ent_in    (mem_resp_rdata),
        .set_dirty (wr_q),
        .ent_out   (leaf_upd),
        .changed   (leaf_chg)
    );

    pt_entry_update #(.ENT_W(ADDR_W)) u_dir_upd (
        .ent_in    (dir_ent_q),
        .set_dirty (1'b0),
        .ent_out   (dir_upd),
        .changed   (dir_chg)
    );

    // Walk sequencer: captures the request, steps through reads and write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            root_q      <= '0;
            va_q        <= '0;
            dir_ent_q   <= '0;
            leaf_addr_q <= '0;
            leaf_new_q  <= '0;
            dir_new_q   <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            large_q     <= 1'b0;
            wp_q        <= 1'b0;
            wb_leaf_q   <= 1'b0;
            wb_dir_q    <= 1'b0;
            cause_q     <= '0;
            fault_q     <= 1'b0;
            paddr_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        root_q  <= root_base;
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        large_q <= large_en;
                        wp_q    <= wp_en;
                        fault_q <= 1'b0;
                        cause_q <= '0;
                        state   <= ST_DIR_REQ;
                    end
                end
                ST_DIR_REQ: state <= ST_DIR_WAIT;
                ST_DIR_WAIT: begin
                    if (mem_resp_valid) begin
                        dir_ent_q <= mem_resp_rdata;
                        if (!resp_present) begin
                            fault_q        <= 1'b1;
                            cause_q.absent <= 1'b1;
                            state          <= ST_DONE;
                        end else if (is_large) begin
                            if (user_denied || write_denied) begin
                                fault_q              <= 1'b1;
                                cause_q.user_denied  <= user_denied;
                                cause_q.write_denied <= write_denied;
                                state                <= ST_DONE;
                            end else begin
                                paddr_q     <= pa_large;
                                leaf_new_q  <= leaf_upd;
                                leaf_addr_q <= dir_addr;
                                wb_leaf_q   <= leaf_chg;
                                wb_dir_q    <= 1'b0;
                                state       <= leaf_chg ? ST_WB_REQ : ST_DONE;
                            end
                        end else begin
                            state <= ST_TBL_REQ;
                        end
                    end
                end
                ST_TBL_REQ: state <= ST_TBL_WAIT;
                ST_TBL_WAIT: begin
                    if (mem_resp_valid) begin
                        if (!resp_present) begin
                            fault_q        <= 1'b1;
                            cause_q.absent <= 1'b1;
                            state          <= ST_DONE;
                        end else if (user_denied || write_denied) begin
                            fault_q              <= 1'b1;
                            cause_q.user_denied  <= user_denied;
                            cause_q.write_denied <= write_denied;
                            state                <= ST_DONE;
                        end else begin
                            paddr_q     <= pa_small;
                            leaf_new_q  <= leaf_upd;
                            leaf_addr_q <= tbl_addr;
                            dir_new_q   <= dir_upd;
                            wb_leaf_q   <= leaf_chg;
                            wb_dir_q    <= dir_chg;
                            state       <= (leaf_chg || dir_chg) ? ST_WB_REQ : ST_DONE;
                        end
                    end
                end
                ST_WB_REQ: state <= ST_WB_WAIT;
                ST_WB_WAIT: begin
                    if (mem_resp_valid) begin
                        if (wb_leaf_q) begin
                            wb_leaf_q <= 1'b0;
                            state     <= wb_dir_q ? ST_WB_REQ : ST_DONE;
                        end else begin
                            wb_dir_q <= 1'b0;
                            state    <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port and result outputs decoded from the current state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_DIR_REQ) || (state == ST_TBL_REQ) || (state == ST_WB_REQ);
        mem_req_write = (state == ST_WB_REQ);
        mem_req_addr  = dir_addr;
        mem_req_wdata = '0;
        if (state == ST_TBL_REQ) begin
            mem_req_addr = tbl_addr;
        end else if (state == ST_WB_REQ) begin
            mem_req_addr  = wb_leaf_q ? leaf_addr_q : dir_addr;
            mem_req_wdata = wb_leaf_q ? leaf_new_q : dir_new_q;
        end
        done_valid = (state == ST_DONE);
        done_fault = fault_q;
        done_cause = cause_q;
        done_paddr = paddr_q;
    end

endmodule

// File: rtl/pt_walker_chk.sv
// Module: pt_walker_chk
// Protocol and hold checks on the walker's ports, bound to every instance.
module pt_walker_chk
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WB_LOG2 = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [ADDR_W-1:0] mem_req_wdata,
    input logic              done_valid,
    input logic              done_fault,
    input logic [2:0]        done_cause,
    input logic [ADDR_W-1:0] done_paddr
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_single_mem_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    assert_idle_no_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    assert_entry_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[WB_LOG2-1:0] == '0));

    assert_wb_accessed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[BIT_ACCESSED]);

    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_fault && !(req_valid && req_ready)) |=> done_fault);

    assert_paddr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(done_paddr));

    assert_success_no_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> (done_cause == 3'b000));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .WB_LOG2(WB_LOG2)) u_pt_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_cause    (done_cause),
    .done_paddr    (done_paddr)
);

// File: tb/tb_pt_walker.sv
// Bench for pt_walker: a table of walks with expected outcome and memory
// traffic, then directed checks on reset, result hold and final memory.
module tb_pt_walker;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;
    localparam int N_VEC      = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = 32'h0000_1000;
    logic        large_en = 1'b0, wp_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_rdata = '0;
    logic        done_valid, done_fault;
    logic [2:0]  done_cause;
    logic [31:0] done_paddr;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base), .large_en(large_en),
        .wp_en(wp_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata),
        .done_valid(done_valid), .done_fault(done_fault),
        .done_cause(done_cause), .done_paddr(done_paddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0, cycles = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] mem [MEM_WORDS];
    logic        mbusy = 1'b0;
    int          mdly = 0;
    logic [31:0] mrd = '0;

    // Memory model: acts on the falling edge, answers after a short delay.
    always @(negedge clk) begin
        if (!rst_n) begin
            mbusy = 1'b0;
            mem_resp_valid = 1'b0;
        end else begin
            mem_resp_valid = 1'b0;
            if (mbusy) begin
                if (mdly == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_rdata = mrd;
                    mbusy = 1'b0;
                end else mdly--;
            end
            if (mem_req_valid) begin
                mbusy = 1'b1;
                mdly = 1;
                if (mem_req_addr[31:14] != 0) mrd = 32'h0;
                else if (mem_req_write) begin
                    mem[mem_req_addr[13:2]] = mem_req_wdata;
                    wr_cnt++;
                end else begin
                    mrd = mem[mem_req_addr[13:2]];
                    rd_cnt++;
                end
            end
        end
    end

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        wr, usr, wp, lg;
        logic [2:0]  cause;
        logic [31:0] pa;
        logic [1:0]  nrd, nwr;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{32'h0000_0ABC, 0,1,0,1, 3'b000, 32'h1234_5ABC, 2, 2, 4'd1}, // R1 R6 dir+leaf accessed
        '{32'h0000_0ABC, 1,1,0,1, 3'b000, 32'h1234_5ABC, 2, 1, 4'd6}, // R6 dirty
        '{32'h0000_1010, 1,1,0,1, 3'b010, 32'h0,         2, 0, 4'd5}, // R5 user write RO
        '{32'h0000_1010, 0,1,0,1, 3'b000, 32'h2222_2010, 2, 1, 4'd1}, // R1
        '{32'h0000_2020, 0,1,0,1, 3'b100, 32'h0,         2, 0, 4'd4}, // R4 leaf not user
        '{32'h0000_2020, 1,0,1,1, 3'b000, 32'h3333_3020, 2, 1, 4'd5}, // R5 sup write RW
        '{32'h0000_3000, 0,0,0,1, 3'b001, 32'h0,         2, 0, 4'd3}, // R3 leaf absent
        '{32'h0080_0004, 0,0,0,1, 3'b001, 32'h0,         1, 0, 4'd3}, // R3 dir absent
        '{32'h0040_1234, 0,0,0,1, 3'b000, 32'h0800_1234, 1, 1, 4'd2}, // R2 R7 large page
        '{32'h0040_1234, 0,1,0,1, 3'b100, 32'h0,         1, 0, 4'd4}, // R4 large not user
        '{32'h0140_0ABC, 0,1,0,0, 3'b000, 32'h1234_5ABC, 2, 1, 4'd2}, // R2 size ignored
        '{32'h0140_0ABC, 0,1,0,1, 3'b000, 32'h0000_0ABC, 1, 0, 4'd2}, // R2 R6 no change
        '{32'h00C0_0100, 0,1,0,1, 3'b100, 32'h0,         2, 0, 4'd4}, // R4 dir not user
        '{32'h00C0_0100, 1,0,1,1, 3'b000, 32'h6666_6100, 2, 2, 4'd6}, // R6 two write-backs
        '{32'h0000_1010, 1,0,0,1, 3'b000, 32'h2222_2010, 2, 1, 4'd5}, // R5 wp low
        '{32'h0000_1010, 1,0,1,1, 3'b010, 32'h0,         2, 0, 4'd5}, // R5 wp high
        '{32'h0100_0008, 1,1,0,1, 3'b010, 32'h0,         1, 0, 4'd5}, // R5 large RO
        '{32'h0100_0008, 0,1,0,1, 3'b000, 32'h0C00_0008, 1, 1, 4'd2}, // R2
        '{32'h0180_0ABC, 1,1,0,1, 3'b010, 32'h0,         2, 0, 4'd5}, // R5 dir RO
        '{32'h0000_4000, 1,1,0,1, 3'b000, 32'h5555_5000, 2, 0, 4'd6}, // R6 R7 flags set
        '{32'h0180_0ABC, 0,1,0,1, 3'b000, 32'h1234_5ABC, 2, 1, 4'd6}  // R6
    };

    task automatic start_req(input logic [31:0] va, input logic wr, input logic usr,
                             input logic wp, input logic lg);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        req_vaddr = va; req_write = wr; req_user = usr; wp_en = wp; large_en = lg;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_valid) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        mem['h400] = 32'h0000_2007;
        mem['h401] = 32'h083F_FE83;
        mem['h402] = 32'h0000_2006;
        mem['h403] = 32'h0000_3003;
        mem['h404] = 32'h0C00_0085;
        mem['h405] = 32'h0000_2087;
        mem['h406] = 32'h0000_2005;
        mem['h800] = 32'h1234_5007;
        mem['h801] = 32'h2222_2005;
        mem['h802] = 32'h3333_3003;
        mem['h803] = 32'h4444_4006;
        mem['h804] = 32'h5555_5E67;
        mem['hC00] = 32'h6666_6007;

        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R9 no mem req in reset", {31'b0, mem_req_valid}, 32'd0);
        chk("R9 no done in reset", {31'b0, done_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {31'b0, req_ready, mem_req_valid, done_fault}, 32'd4);

        for (int v = 0; v < N_VEC; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            start_req(VECS[v].va, VECS[v].wr, VECS[v].usr, VECS[v].wp, VECS[v].lg);
            chk({tag, " busy"}, {31'b0, req_ready}, 32'd0);
            wait_done();
            chk({tag, " fault"}, {29'b0, done_fault, 2'b0}, {29'b0, (VECS[v].cause != 0), 2'b0});
            chk({tag, " cause"}, {29'b0, done_cause}, {29'b0, VECS[v].cause});
            if (VECS[v].cause == 0) chk({tag, " paddr"}, done_paddr, VECS[v].pa);
            chk({tag, " reads"}, rd_cnt, {30'b0, VECS[v].nrd});
            chk({tag, " writes"}, wr_cnt, {30'b0, VECS[v].nwr});
        end

        // R8: fault and cause hold while idle, clear on acceptance
        start_req(32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b1);
        wait_done();
        repeat (3) @(negedge clk);
        chk("R8 fault held", {28'b0, done_fault, done_cause}, 32'h9);
        @(negedge clk);
        req_vaddr = 32'h0000_0ABC; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 fault cleared on accept", {28'b0, done_fault, done_cause}, 32'h0);
        wait_done();
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8 paddr held", done_paddr, 32'h1234_5ABC);

        // R6 R7 R3: final memory image
        chk("R6 dir0 accessed", mem['h400], 32'h0000_2027);
        chk("R6 leaf0 dirty", mem['h800], 32'h1234_5067);
        chk("R6 leaf1 dirty after sup write", mem['h801], 32'h2222_2065);
        chk("R6 leaf2", mem['h802], 32'h3333_3063);
        chk("R3 absent leaf untouched", mem['h803], 32'h4444_4006);
        chk("R3 absent dir untouched", mem['h402], 32'h0000_2006);
        chk("R7 software bits kept", mem['h804], 32'h5555_5E67);
        chk("R7 large entry bits kept", mem['h401], 32'h083F_FEA3);
        chk("R6 dir3 accessed", mem['h403], 32'h0000_3023);
        chk("R6 read leaves no dirty", mem['h404], 32'h0C00_00A5);
        chk("R6 dir6 accessed", mem['h406], 32'h0000_2025);
        chk("R6 table2 leaf", mem['hC00], 32'h6666_6067);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule